// File: doc/BRIEF.md
# Random-Replacement Instruction Cache Tag Model

This block is a timing model of a read-only, set-associative cache directory. It holds tags and valid bits only. It takes one byte address at a time over a valid/ready handshake and decides whether that address hits a resident block. On a miss it claims a way in the indexed set. The lowest-numbered empty way is taken first. Once the set is full, a way chosen by a free-running pseudo-random generator is overwritten.

Each accepted access produces a one-cycle response. The response carries the hit flag and the number of cycles the access costs: one for a hit, and log2 of the block size in bytes for a miss. The block stays not-ready for the remainder of a miss's cost, so accesses are serialised exactly as the modelled timing dictates. Three 32-bit counters track accesses, misses and total cycles. Miss rate and average access time are then two divisions done outside. A flush input empties the directory and zeroes the counters.

Cache capacity, block size and way count are parameters. Addresses are 20 bits wide.

Top module: `icache_tag_model`

## Requirements
- R1: An address splits into offset (low log2(BLOCK_BYTES) bits), set index (next log2(CACHE_BYTES/(BLOCK_BYTES*WAYS)) bits) and tag (remaining upper bits). Two addresses that differ only in offset bits refer to the same block, so the second access hits.
- R2: An accepted access is answered by rsp_valid high in the next cycle. A hit answers with rsp_hit=1 and rsp_cycles=1, and req_ready is high again in that response cycle.
- R3: A miss answers with rsp_hit=0 and rsp_cycles=log2(BLOCK_BYTES). req_ready then stays low for exactly log2(BLOCK_BYTES)-1 cycles after the accepting edge.
- R4: While a set still has an empty way, a miss fills an empty way, so every distinct block that has been accessed in that set since the last flush still hits.
- R5: When every way of the set is valid, a miss replaces one way chosen pseudo-randomly. The block just loaded hits on its next access. A direct-mapped configuration always replaces way 0.
- R6: stat_accesses increases by one per accepted access and stat_misses by one per miss. stat_cycles increases by 1 per hit and by log2(BLOCK_BYTES) per miss.
- R7: A cycle with flush high clears every valid bit and zeroes all three counters. req_ready is low in that cycle, so no access is accepted alongside a flush.
- R8: After reset, all counters read zero, rsp_valid is low, the directory is empty and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the directory and zero the counters |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept an access this cycle |
| req_addr | input | 20 | Byte address of the access |
| rsp_valid | output | 1 | One-cycle response to the previous accepted access |
| rsp_hit | output | 1 | Response was a hit |
| rsp_cycles | output | 4 | Cycles charged for the access |
| stat_accesses | output | 32 | Accepted access count |
| stat_misses | output | 32 | Miss count |
| stat_cycles | output | 32 | Accumulated access cycles |

## Verification
A flush and a pending access can land in the same cycle. The flush must win: the access must not be accepted, counted or allocated in that cycle. The bench raises flush together with a held request, and checks that req_ready is low and the counters read zero afterwards. It then checks that the held request is accepted later as a miss against the emptied directory. Random victim choice cannot be predicted, so the bench keeps a model that only tracks blocks known to be resident. It requires exact results while a set has free ways, and after an eviction it requires only that the newly loaded block is present.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int ADDR_W = 20;
    localparam int STAT_W = 32;
    localparam int LAT_W  = 4;
    localparam int RND_W  = 16;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [LAT_W-1:0] cycles;
    } rsp_t;

    typedef struct packed {
        logic             bump;
        logic             miss;
        logic [LAT_W-1:0] cost;
    } stat_evt_t;

    function automatic logic [LAT_W-1:0] miss_cost(input int block_bytes);
        return LAT_W'($clog2(block_bytes));
    endfunction

endpackage

// File: rtl/icache_addr_split.sv
module icache_addr_split #(
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic unused_offset;

    assign idx = addr[OFF_W +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = ^addr[OFF_W-1:0];
endmodule

// File: rtl/icache_lfsr.sv
module icache_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 1,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] state_q;
    logic         unused_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W'(SEED);
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ W'(16'hB400);
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign rnd       = state_q[OUT_W-1:0];
    assign unused_hi = ^state_q[W-1:OUT_W];
endmodule

// File: rtl/icache_way_pick.sv
module icache_way_pick #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 11,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_vld,
    input  logic [TAG_W-1:0]           tag,
    input  logic [WAY_W-1:0]           rnd,
    output logic                       hit,
    output logic [WAY_W-1:0]           fill_way
);
    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] victim;
    logic             any_free;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_vld[w] && (set_tags[w] == tag);
    end

    if (WAYS == 1) begin : g_direct
        logic unused_rnd;
        assign victim     = '0;
        assign unused_rnd = ^rnd;
    end else begin : g_assoc
        assign victim = rnd;
    end

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_vld[w]) free_way = WAY_W'(w);
        end
    end

    assign any_free = ~&set_vld;
    assign hit      = |match;
    assign fill_way = any_free ? free_way : victim;
endmodule

// File: rtl/icache_stats.sv
module icache_stats
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  stat_evt_t         evt,
    output logic [STAT_W-1:0] n_access,
    output logic [STAT_W-1:0] n_miss,
    output logic [STAT_W-1:0] n_cycle
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            n_access <= '0;
            n_miss   <= '0;
            n_cycle  <= '0;
        end else if (evt.bump) begin
            n_access <= n_access + 1'b1;
            n_cycle  <= n_cycle + STAT_W'(evt.cost);
            if (evt.miss) n_miss <= n_miss + 1'b1;
        end
    end
endmodule

// File: rtl/icache_tag_model.sv
module icache_tag_model
    import icache_pkg::*;
#(
    parameter int          CACHE_BYTES = 1024,
    parameter int          BLOCK_BYTES = 32,
    parameter int          WAYS        = 2,
    parameter logic [15:0] RND_SEED    = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LAT_W-1:0]  rsp_cycles,
    output logic [STAT_W-1:0] stat_accesses,
    output logic [STAT_W-1:0] stat_misses,
    output logic [STAT_W-1:0] stat_cycles
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [LAT_W-1:0] MISS_LAT = miss_cost(BLOCK_BYTES);

    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    logic [WAYS-1:0]            vld_q [SETS];
    logic [LAT_W-1:0]           busy_q;
    rsp_t                       rsp_q;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic [WAY_W-1:0] rnd;
    logic [WAY_W-1:0] fill_way;
    logic             hit;
    logic             accept;
    stat_evt_t        evt;

    icache_addr_split #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) i_split (
        .addr(req_addr), .idx(idx), .tag(tag)
    );

    icache_lfsr #(
        .W(RND_W), .OUT_W(WAY_W), .SEED(RND_SEED)
    ) i_lfsr (
        .clk(clk), .rst(rst), .rnd(rnd)
    );

    icache_way_pick #(
        .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) i_pick (
        .set_tags(tag_q[idx]), .set_vld(vld_q[idx]), .tag(tag),
        .rnd(rnd), .hit(hit), .fill_way(fill_way)
    );

    assign req_ready = (busy_q == '0) && !flush && !rst;
    assign accept    = req_valid && req_ready;

    always_comb begin
        evt.bump = accept;
        evt.miss = !hit;
        evt.cost = hit ? LAT_W'(1) : MISS_LAT;
    end

    icache_stats i_stats (
        .clk(clk), .rst(rst), .clr(flush), .evt(evt),
        .n_access(stat_accesses), .n_miss(stat_misses), .n_cycle(stat_cycles)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (accept && !hit) begin
            vld_q[idx][fill_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept && !hit) tag_q[idx][fill_way] <= tag;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy_q <= '0;
        end else if (accept && !hit) begin
            busy_q <= MISS_LAT - 1'b1;
        end else if (busy_q != '0) begin
            busy_q <= busy_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid  <= accept;
            rsp_q.hit    <= hit;
            rsp_q.cycles <= evt.cost;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_hit    = rsp_q.hit;
    assign rsp_cycles = rsp_q.cycles;
endmodule

// File: rtl/icache_tag_chk.sv
module icache_tag_chk
    import icache_pkg::*;
#(
    parameter int BLOCK_BYTES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [LAT_W-1:0]  rsp_cycles,
    input logic [STAT_W-1:0] stat_accesses,
    input logic [STAT_W-1:0] stat_misses,
    input logic [STAT_W-1:0] stat_cycles
);
    localparam logic [LAT_W-1:0] LAT = miss_cost(BLOCK_BYTES);

    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    a_r2_hit_cost: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (rsp_cycles == LAT_W'(1)));

    a_r3_miss_cost: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_cycles == LAT));

    a_r3_stall_after_miss: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> !req_ready);

    a_r6_miss_count: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (stat_misses == $past(stat_misses) + 1'b1));

    a_r6_access_count: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (stat_accesses == $past(stat_accesses) + 1'b1));

    a_r7_flush_blocks: assert property (@(posedge clk) disable iff (rst)
        flush |-> !req_ready);

    a_r7_flush_zeroes: assert property (@(posedge clk) disable iff (rst)
        flush |=> (stat_accesses == '0 && stat_misses == '0 && stat_cycles == '0));
endmodule

bind icache_tag_model icache_tag_chk #(.BLOCK_BYTES(BLOCK_BYTES)) i_chk (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_cycles(rsp_cycles), .stat_accesses(stat_accesses),
    .stat_misses(stat_misses), .stat_cycles(stat_cycles)
);

// File: tb/test_icache_tag_model.sv
module test_icache_tag_model;
    localparam int CB   = 1024;
    localparam int BB   = 32;
    localparam int WY   = 2;
    localparam int OFF  = 5;
    localparam int SETS = CB / (BB * WY);
    localparam int IDXW = 4;
    localparam int LAT  = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [3:0]  rsp_cycles;
    logic [31:0] stat_accesses, stat_misses, stat_cycles;

    int total = 0;
    int bad = 0;
    int exp_acc = 0, exp_miss = 0, exp_cyc = 0;
    int cyc_count = 0;
    bit done = 0;

    logic [19:0] known_tag [SETS][WY];
    int known_n [SETS];
    int fill_n [SETS];

    always #5 clk = ~clk;

    icache_tag_model #(.CACHE_BYTES(CB), .BLOCK_BYTES(BB), .WAYS(WY)) i_icache_tag_model (
        .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_cycles(rsp_cycles), .stat_accesses(stat_accesses),
        .stat_misses(stat_misses), .stat_cycles(stat_cycles)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SETS; s++) begin
            known_n[s] = 0;
            fill_n[s]  = 0;
        end
        exp_acc = 0; exp_miss = 0; exp_cyc = 0;
    endtask

    task automatic check_stats(input string req);
        check(stat_accesses == 32'(exp_acc), req, "stat_accesses", stat_accesses, exp_acc);
        check(stat_misses == 32'(exp_miss), req, "stat_misses", stat_misses, exp_miss);
        check(stat_cycles == 32'(exp_cyc), req, "stat_cycles", stat_cycles, exp_cyc);
    endtask

    task automatic access(input logic [19:0] a, output bit hit);
        int s;
        logic [19:0] t;
        int pos;
        int n;
        s = int'(a[OFF +: IDXW]);
        t = a >> (OFF + IDXW);
        pos = -1;
        for (int k = 0; k < known_n[s]; k++) if (known_tag[s][k] == t) pos = k;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R2", "rsp_valid after accept", rsp_valid, 1);
        hit = rsp_hit;
        if (pos >= 0)
            check(hit == 1'b1, "R5", "resident block hits", hit, 1);
        else if (fill_n[s] < WY)
            check(hit == 1'b0, "R4", "new block in non-full set misses", hit, 0);
        exp_acc++;
        if (hit) begin
            exp_cyc += 1;
            check(rsp_cycles == 4'd1, "R2", "hit cycles", rsp_cycles, 1);
            check(req_ready == 1'b1, "R2", "ready after hit", req_ready, 1);
            check_stats("R6");
            if (pos < 0) begin
                known_tag[s][known_n[s]] = t;
                known_n[s]++;
            end
        end else begin
            exp_miss++;
            exp_cyc += LAT;
            check(rsp_cycles == 4'(LAT), "R3", "miss cycles", rsp_cycles, LAT);
            check_stats("R6");
            n = 0;
            while (!req_ready && n < 20) begin
                n++;
                @(negedge clk);
            end
            check(n == LAT - 1, "R3", "stall cycles after miss", n, LAT - 1);
            if (fill_n[s] < WY) begin
                fill_n[s]++;
                known_tag[s][known_n[s]] = t;
                known_n[s]++;
            end else begin
                known_n[s] = 1;
                known_tag[s][0] = t;
            end
        end
    endtask

    task automatic do_flush_with_request(input logic [19:0] a);
        bit h;
        @(negedge clk);
        flush = 1'b1;
        req_valid = 1'b1;
        req_addr = a;
        #1;
        check(req_ready == 1'b0, "R7", "ready low during flush", req_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        model_clear();
        check_stats("R7");
        req_valid = 1'b0;
        access(a, h);
        check(h == 1'b0, "R7", "access after flush misses", h, 0);
    endtask

    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > 150000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL R0 watchdog expired: actual=%0d expected=%0d", cyc_count, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit h;
        logic [19:0] a;
        logic [19:0] base;
        void'($urandom(32'd2024));
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R8 reset state
        check(rsp_valid == 1'b0, "R8", "rsp_valid after reset", rsp_valid, 0);
        check(req_ready == 1'b1, "R8", "req_ready after reset", req_ready, 1);
        check_stats("R8");

        // R1 same block, different offsets
        base = 20'h0_1240;
        access(base, h);
        check(h == 1'b0, "R8", "first access to empty cache misses", h, 0);
        access(base + 20'(BB - 1), h);
        check(h == 1'b1, "R1", "other byte of same block hits", h, 1);
        access(base + 20'(BB), h);
        check(h == 1'b0, "R1", "next block misses", h, 0);

        // R4 and R5 set conflicts: stride of SETS*BB maps to the same set
        base = 20'h4_0000;
        access(base, h);
        access(base + 20'(SETS * BB), h);
        access(base, h);
        check(h == 1'b1, "R4", "first of two blocks still resident", h, 1);
        access(base + 20'(SETS * BB), h);
        check(h == 1'b1, "R4", "second of two blocks still resident", h, 1);
        access(base + 20'(2 * SETS * BB), h);
        check(h == 1'b0, "R5", "third block in full set misses", h, 0);
        access(base + 20'(2 * SETS * BB), h);
        check(h == 1'b1, "R5", "freshly loaded block hits", h, 1);

        // R7 flush colliding with a held request
        do_flush_with_request(base);

        // wrap-around at the top of the address space
        access(20'hF_FFFF, h);
        access(20'h0_0000, h);

        // mixed sequential / jump stream on a circular 1 MiB space
        a = 20'h0;
        for (int i = 0; i < 2500; i++) begin
            access(a, h);
            if ($urandom_range(99) < 90) begin
                a = a + 20'd1;
            end else if ($urandom_range(1) == 0) begin
                a = a + 20'($urandom_range(1000, 500));
            end else begin
                a = a - 20'($urandom_range(1000, 500));
            end
            if (i == 1200) do_flush_with_request(a);
        end
        check_stats("R6");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule